// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a single 16-bit word from a three-wire serial EEPROM that speaks the Microwire protocol. A caller presents an address, picks the device size with one select input and pulses `start`. The block raises chip select and serially sends a read frame made of a start bit, a two-bit read opcode and the word address. It then clocks 16 data bits back from the memory, returns them on `rdata` and pulses `done`.

Two device sizes are handled. The small part takes a 6-bit address, so its frame is 9 bits long. The large part takes an 8-bit address, so its frame is 11 bits long. The serial clock is derived from the system clock. Its low and high phases each last a programmable number of system clocks.

A typical use is reading a station hardware address at power-up. That address is stored as three consecutive words beginning at word 7, so the caller issues three back-to-back reads.

Top module: `mw_eeprom_reader`

## Requirements
- R1: The serial frame starts with a 1 start bit, followed by the read opcode bits 1 then 0, followed by the address. All frame bits are sent most significant bit first on `ee_di`.
- R2: With `wide_sel`=0 the frame is 9 bits long and carries a 6-bit address. With `wide_sel`=1 it is 11 bits long and carries an 8-bit address. Exactly 16 further SK rising edges follow the frame, for a total of 25 or 27 rising edges per transfer.
- R3: With `wide_sel`=0, only `addr[5:0]` is sent, and `addr[7:6]` has no effect on the frame or the word returned.
- R4: `ee_di` changes only while `ee_sk` is low. It never changes while SK is high, nor in the same cycle in which SK rises.
- R5: After the frame, 16 bits are read from `ee_do` most significant bit first. Each bit is sampled at the end of an SK high phase. The assembled word appears on `rdata` in the cycle in which `done` is high.
- R6: Every SK low phase and every SK high phase lasts max(`half_period`,1) system clocks, so a `half_period` of 0 behaves as 1.
- R7: `ee_cs` rises before the first SK rising edge and stays high for the whole transfer. When the transfer ends, `ee_cs`, `ee_sk` and `ee_di` are all 0 in the same cycle in which `done` is high.
- R8: `busy` is high from the clock edge that accepts `start` until `done`, for exactly (frame length + 16) × 2 × max(`half_period`,1) cycles. `done` is a single-cycle pulse, and `busy` is low while `done` is high.
- R9: A `start` pulse while `busy` is high is ignored. The transfer in progress keeps its address and its timing, and no second transfer follows.
- R10: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to read a word |
| wide_sel | input | 1 | 0: 6-bit address device, 1: 8-bit address device |
| addr | input | LARGE_AW (8) | Word address, sampled with `start` |
| half_period | input | DIV_W (8) | SK phase length in system clocks (0 acts as 1) |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when `rdata` is valid |
| rdata | output | WORD_W (16) | Word read from the EEPROM |

## Verification
The bench goes after the frame length switch between the two device sizes. A design that used the wrong length would leave the model still decoding address bits when data should flow, and every word would come back shifted. It sends addresses with the top two bits set to the small device, where an unmasked or misaligned address reaches the model as the wrong word. It also checks a `half_period` of 0, where a missing floor would make the phase counter wrap and stretch each phase to 256 clocks. A `start` pulse injected mid-transfer must leave the address, the cycle count and the idle period afterwards untouched. Phase widths and DI changes are measured on every SK edge, which exposes data launched on the wrong clock edge and bits sampled at the wrong moment.

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int DIV_W    = 8,
  parameter int WORD_W   = 16,
  parameter int SMALL_AW = 6,
  parameter int LARGE_AW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wide_sel,
  input  logic [LARGE_AW-1:0] addr,
  input  logic [DIV_W-1:0]    half_period,
  input  logic                ee_do,
  output logic                ee_cs,
  output logic                ee_sk,
  output logic                ee_di,
  output logic                busy,
  output logic                done,
  output logic [WORD_W-1:0]   rdata
);

  localparam int CMD_MAX   = 3 + LARGE_AW;
  localparam int SMALL_LEN = 3 + SMALL_AW;
  localparam int IDX_W     = $clog2(CMD_MAX + WORD_W);
  localparam logic [IDX_W-1:0] LAST_LARGE = IDX_W'(CMD_MAX - 1);
  localparam logic [IDX_W-1:0] LAST_SMALL = IDX_W'(SMALL_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_WORD  = IDX_W'(WORD_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_DATA} state_t;

  state_t              state;
  logic [CMD_MAX-1:0]  frame_q;
  logic [IDX_W-1:0]    bits_q;
  logic [DIV_W-1:0]    cnt_q;
  logic [WORD_W-2:0]   shift_q;
  logic [DIV_W-1:0]    plen;
  logic [CMD_MAX-1:0]  frame_new;

  assign plen = (half_period == '0) ? DIV_W'(1) : half_period;
  assign busy = (state != S_IDLE);
  assign frame_new = wide_sel
    ? {3'b110, addr}
    : {3'b110, addr[SMALL_AW-1:0], {(LARGE_AW-SMALL_AW){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      frame_q <= '0;
      bits_q  <= '0;
      cnt_q   <= '0;
      shift_q <= '0;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
      ee_di   <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_CMD;
          frame_q <= frame_new;
          bits_q  <= wide_sel ? LAST_LARGE : LAST_SMALL;
          cnt_q   <= plen - DIV_W'(1);
          ee_cs   <= 1'b1;
          ee_sk   <= 1'b0;
          ee_di   <= frame_new[CMD_MAX-1];
        end
        default: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - DIV_W'(1);
          end else if (!ee_sk) begin
            ee_sk <= 1'b1;
            cnt_q <= plen - DIV_W'(1);
          end else begin
            ee_sk <= 1'b0;
            cnt_q <= plen - DIV_W'(1);
            if (state == S_CMD) begin
              frame_q <= frame_q << 1;
              if (bits_q == '0) begin
                state  <= S_DATA;
                bits_q <= LAST_WORD;
                ee_di  <= 1'b0;
              end else begin
                bits_q <= bits_q - IDX_W'(1);
                ee_di  <= frame_q[CMD_MAX-2];
              end
            end else begin
              shift_q <= {shift_q[WORD_W-3:0], ee_do};
              if (bits_q == '0) begin
                state <= S_IDLE;
                ee_cs <= 1'b0;
                ee_di <= 1'b0;
                done  <= 1'b1;
                rdata <= {shift_q, ee_do};
              end else begin
                bits_q <= bits_q - IDX_W'(1);
              end
            end
          end
        end
      endcase
    end
  end

  // R4: data to the EEPROM holds while the serial clock is high
  a_r4_di_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> $stable(ee_di));

  // R7: the serial clock only toggles inside a selected transfer
  a_r7_sk_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  // R7: all lines are low whenever no transfer runs
  a_r7_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !ee_di));

  // R8: done closes a busy period
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a request seen while busy starts nothing new
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !$past(done)) |=> (busy || done));

endmodule

// File: tb/tb_mw_eeprom_reader.sv
module tb_mw_eeprom_reader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wide_sel = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] half_period = 8'd1;
  logic ee_do = 1'b0;
  logic ee_cs, ee_sk, ee_di, busy, done;
  logic [15:0] rdata;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  mw_eeprom_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_sel(wide_sel),
    .addr(addr), .half_period(half_period), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .busy(busy), .done(done), .rdata(rdata)
  );

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    return {a ^ 8'hA5, ~a} ^ {a[3:0], 12'h3C1};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // EEPROM model
  bit          m_wide;
  int          m_cnt, m_rises, m_ptr;
  bit          m_reading;
  logic [10:0] m_frame;
  logic [7:0]  m_addr;
  logic [15:0] m_word;

  always @(posedge ee_cs) begin
    m_cnt = 0; m_rises = 0; m_reading = 0; m_frame = '0; ee_do = 1'b0;
  end

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      m_rises++;
      if (!m_reading) begin
        m_frame = {m_frame[9:0], ee_di};
        m_cnt++;
        if (m_cnt == (m_wide ? 11 : 9)) begin
          m_reading = 1;
          m_addr = m_wide ? m_frame[7:0] : {2'b00, m_frame[5:0]};
          m_word = mem_word(m_addr);
          m_ptr = 15;
        end
      end
    end
  end

  always @(negedge ee_sk) begin
    if (m_reading && m_ptr >= 0) begin
      ee_do = m_word[m_ptr];
      m_ptr--;
    end
  end

  // line monitor
  int   phase_err = 0, di_err = 0, run = 0, cur_n = 1;
  logic prev_sk = 0, prev_di = 0, prev_cs = 0;
  always @(negedge clk) begin
    if (ee_sk && ee_di !== prev_di) di_err++;
    if (ee_cs && !prev_cs) run = 1;
    else if (ee_sk !== prev_sk) begin
      if (ee_cs || prev_sk) if (run != cur_n) phase_err++;
      run = 1;
    end else run++;
    prev_sk = ee_sk; prev_di = ee_di; prev_cs = ee_cs;
  end

  // scoreboard
  logic [15:0] exp_q[$];
  always @(negedge clk) begin
    if (done) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected done", rdata, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rdata === e, "R5 rdata", rdata, e);
      end
      check(!ee_cs && !ee_sk && !ee_di && !busy, "R7/R8 lines at done",
            {ee_cs, ee_sk, ee_di, busy}, 0);
    end
  end

  task automatic do_read(input bit wide, input logic [7:0] a, input logic [7:0] n,
                         input bit poke);
    int n_eff, len, cyc;
    logic [7:0] am;
    logic [10:0] fexp;
    n_eff = (n == 0) ? 1 : int'(n);
    len = wide ? 11 : 9;
    am = wide ? a : {2'b00, a[5:0]};
    fexp = wide ? {3'b110, am} : {2'b00, 3'b110, am[5:0]};
    @(negedge clk);
    m_wide = wide; cur_n = n_eff; phase_err = 0; di_err = 0;
    wide_sel = wide; addr = a; half_period = n;
    exp_q.push_back(mem_word(am));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done) begin
      if (busy) cyc++;
      if (!ee_cs && busy) check(0, "R7 cs dropped", 0, 1);
      if (poke && cyc == 7) begin
        addr = ~a; wide_sel = ~wide; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(cyc == (len + 16) * 2 * n_eff, "R8/R6 busy cycles", cyc, (len + 16) * 2 * n_eff);
    check(m_rises == len + 16, "R2 sk rises", m_rises, len + 16);
    if (wide) check(m_frame === fexp, "R1/R2 wide frame", m_frame, fexp);
    else check(m_frame[8:0] === fexp[8:0], "R1/R3 small frame", m_frame[8:0], fexp[8:0]);
    check(phase_err == 0, "R6 phase width", phase_err, 0);
    check(di_err == 0, "R4 di during sk high", di_err, 0);
    repeat (4) @(negedge clk);
    check(!busy && !ee_cs, "R9 no follow-on transfer", busy, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, done} == 0 && rdata == 0, "R10 reset outputs",
          {ee_cs, ee_sk, ee_di, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, done} == 0, "R10 idle after reset",
          {ee_cs, ee_sk, ee_di, busy, done}, 0);
    // station address words 7..9, small device
    for (int w = 7; w <= 9; w++) do_read(1'b0, 8'(w), 8'd1, 1'b0);
    do_read(1'b1, 8'hC5, 8'd3, 1'b0);   // R2 large frame, slow clock
    do_read(1'b0, 8'hFF, 8'd2, 1'b0);   // R3 upper bits masked
    do_read(1'b0, 8'hC2, 8'd1, 1'b0);   // R3 same word as 0x02
    do_read(1'b1, 8'h00, 8'd0, 1'b0);   // R6 zero acts as one
    do_read(1'b1, 8'hFF, 8'd1, 1'b0);
    do_read(1'b1, 8'h5A, 8'd2, 1'b1);   // R9 start while busy
    do_read(1'b0, 8'h15, 8'd4, 1'b1);   // R9 on small device
    check(exp_q.size() == 0, "R5 all words returned", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule